// File: doc/BRIEF.md
# Exponential-Step Tracking Approximation Register

This block is the digital loop controller of a tracking converter. It drives a 6-bit code to an external DAC that produces two levels, the code itself and the code plus one. Two comparator flags come back: one is high when the held input sits at or above the upper level, the other when it sits below the lower level. The block then moves the code toward the input. Each further step in the same direction doubles in size. When the input is crossed, the direction reverses and the step drops back to one. At either end of the range the code clamps instead of wrapping.

When both flags are low, the input lies inside the window and the current code is the answer. The block raises `ready` for that cycle, stores the code in `result`, and in the next cycle pulses `sample_req` so that the external sample-and-hold takes a fresh value. The next search starts from the last answer, so a slowly moving input resolves in a few cycles. The output rate therefore depends on how fast the signal moves, and a test circuit can read that rate as a coarse health indicator.

The controller has two states. `ST_FETCH` is the single cycle in which the sample-and-hold loads a new value and the flags are ignored. `ST_TRACK` is the state in which the code steps. The transitions are: `ST_FETCH` to `ST_TRACK` unconditionally; `ST_TRACK` to itself while either flag is high (a step cycle); `ST_TRACK` to `ST_FETCH` when both flags are low (the hold cycle). Reset enters `ST_FETCH`.

Top module: `tsar_track`

## Requirements
- R1: Synchronous active-high `rst` sets `dac_code` to 31 and `result` to 0, drives `ready` and `sample_req` low, and enters `ST_FETCH`.
- R2: In `ST_TRACK`, `in_above`=1 (input at or above `dac_code`+1) makes the code increase and `in_below`=1 (input below `dac_code`) makes it decrease. Both high together is not a legal input.
- R3: The first step of each sample has size 1. Each further step in the same direction doubles the previous size, with a cap of 32 (exponent saturates at 5).
- R4: A step in the opposite direction to the previous step of the same sample has size 1, and doubling restarts from there.
- R5: An increase that would pass 63 leaves the code at 63, and a decrease that would go below 0 leaves it at 0. The code never wraps.
- R6: In `ST_TRACK` with both flags low (hold), `ready` is high for that one cycle and `dac_code` does not change in that cycle or the next.
- R7: The value of `dac_code` during the hold cycle appears on `result` from the next cycle and stays there until the next hold.
- R8: `sample_req` is high for exactly the one cycle after each hold (`ST_FETCH`), `ready` is low in that cycle, and the code does not move in that cycle whatever the flags show.
- R9: After the fetch cycle, `ready` rises after exactly N+1 cycles, where N is the number of steps that R3 to R5 need to reach the input. An unchanged input gives `ready` in the first tracking cycle, and a one-code change gives it in the second.
- R10: With an integer input held by the sample-and-hold, the code at each hold equals the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_above | input | 1 | Comparator: held input at or above upper DAC level (code+1) |
| in_below | input | 1 | Comparator: held input below lower DAC level (code) |
| dac_code | output | 6 | Code driven to the DAC |
| result | output | 6 | Last converged code |
| ready | output | 1 | High during the hold cycle: input lies inside the window |
| sample_req | output | 1 | One-cycle request for the sample-and-hold to load a new value |

## Verification
The assertions assume that the two comparator flags are never high together. They also assume that the flags change only in step with `dac_code` or with the held input, which moves only during the fetch cycle. The bench meets both conditions with an integer comparator model derived from the code and a held value, and it changes that value only at the sample request. Stimulus combines directed jumps, chosen to hit reversal, overflow and underflow clamping, with a seeded sine-plus-noise sequence and full-range random jumps. Every sample's step count is compared against a behavioural search model.

// File: rtl/tsar_pkg.sv
package tsar_pkg;
    localparam int CODE_W     = 6;
    localparam int EXP_W      = 3;
    localparam int EXP_MAX    = 5;
    localparam int CODE_RESET = 31;

    typedef enum logic [0:0] {
        ST_FETCH = 1'b0,
        ST_TRACK = 1'b1
    } tsar_state_e;
endpackage

// File: rtl/tsar_step.sv
// Exponent counter plus one-hot decoder producing the step magnitude.
module tsar_step #(
    parameter int CODE_W  = 6,
    parameter int EXP_W   = 3,
    parameter int EXP_MAX = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              move,
    input  logic              dir_up,
    input  logic              clear,
    output logic [CODE_W-1:0] step
);
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

    logic [EXP_W-1:0] exp_q;
    logic [EXP_W-1:0] eff_exp;
    logic             last_up_q;
    logic             have_dir_q;

    // Same direction as previous step keeps growing; otherwise restart at 0.
    always_comb begin
        if (have_dir_q && (last_up_q == dir_up))
            eff_exp = exp_q;
        else
            eff_exp = '0;
    end

    generate
        for (genvar i = 0; i < CODE_W; i++) begin : g_dec
            assign step[i] = move && (eff_exp == EXP_W'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            exp_q      <= '0;
            last_up_q  <= 1'b0;
            have_dir_q <= 1'b0;
        end else if (move) begin
            exp_q      <= (eff_exp >= EXP_CAP) ? EXP_CAP : eff_exp + 1'b1;
            last_up_q  <= dir_up;
            have_dir_q <= 1'b1;
        end
    end

    AST_EXP_CAP: assert property (@(posedge clk) disable iff (rst)
        exp_q <= EXP_CAP); // R3
    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        move |-> $onehot(step)); // R3
    AST_REVERSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (move && have_dir_q && (last_up_q != dir_up)) |-> (step == CODE_W'(1))); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !move |-> (step == '0)); // R6
endmodule

// File: rtl/tsar_accum.sv
// Saturating up/down accumulator holding the DAC code.
module tsar_accum #(
    parameter int CODE_W     = 6,
    parameter int CODE_RESET = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] step,
    input  logic              sub,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W:0]   sum_w;
    logic [CODE_W:0]   diff_w;
    logic [CODE_W-1:0] code_d;

    always_comb begin
        sum_w  = {1'b0, code} + {1'b0, step};
        diff_w = {1'b0, code} - {1'b0, step};
        if (sub)
            code_d = diff_w[CODE_W] ? '0 : diff_w[CODE_W-1:0];
        else
            code_d = sum_w[CODE_W] ? '1 : sum_w[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            code <= CODE_W'(CODE_RESET);
        else
            code <= code_d;
    end

    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        ((step != '0) && !sub) |=> ((code > $past(code)) || (code == '1))); // R5
    AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
        ((step != '0) && sub) |=> ((code < $past(code)) || (code == '0))); // R5
    AST_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
        (step == '0) |=> $stable(code)); // R6
endmodule

// File: rtl/tsar_track.sv
module tsar_track
    import tsar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_above,
    input  logic              in_below,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result,
    output logic              ready,
    output logic              sample_req
);
    tsar_state_e       state_q;
    tsar_state_e       state_d;
    logic              hold;
    logic              move;
    logic [CODE_W-1:0] step;
    logic [CODE_W-1:0] result_q;
    logic              req_q;

    assign hold = (state_q == ST_TRACK) && !in_above && !in_below;
    assign move = (state_q == ST_TRACK) && (in_above || in_below);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_TRACK;
            ST_TRACK: state_d = hold ? ST_FETCH : ST_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_FETCH;
        else
            state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            req_q    <= 1'b0;
        end else begin
            req_q <= hold;
            if (hold)
                result_q <= dac_code;
        end
    end

    tsar_step #(
        .CODE_W (CODE_W),
        .EXP_W  (EXP_W),
        .EXP_MAX(EXP_MAX)
    ) u_step (
        .clk   (clk),
        .rst   (rst),
        .move  (move),
        .dir_up(in_above),
        .clear (!move),
        .step  (step)
    );

    tsar_accum #(
        .CODE_W    (CODE_W),
        .CODE_RESET(CODE_RESET)
    ) u_accum (
        .clk (clk),
        .rst (rst),
        .step(step),
        .sub (in_below),
        .code(dac_code)
    );

    assign result     = result_q;
    assign ready      = hold;
    assign sample_req = req_q;

    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> ((dac_code == CODE_W'(CODE_RESET)) && !sample_req && (result == '0))); // R1
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_above && in_below)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        ready |=> ($stable(dac_code) && sample_req)); // R6
    AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (rst)
        ready |=> (result == $past(dac_code))); // R7
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_req |-> !ready); // R8
    AST_FETCH_STILL: assert property (@(posedge clk) disable iff (rst)
        sample_req |=> $stable(dac_code)); // R8
    AST_MOVE_UP: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_TRACK) && in_above) |=> ((dac_code > $past(dac_code)) || (dac_code == '1))); // R2
endmodule

// File: tb/sim_tsar_track.sv
module sim_tsar_track;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_above;
    logic       in_below;
    logic [5:0] dac_code;
    logic [5:0] result;
    logic       ready;
    logic       sample_req;

    int vin;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    // Comparator model: integer held input against levels code and code+1
    assign in_above = (vin > int'(dac_code));
    assign in_below = (vin < int'(dac_code));

    tsar_track u0 (
        .clk       (clk),
        .rst       (rst),
        .in_above  (in_above),
        .in_below  (in_below),
        .dac_code  (dac_code),
        .result    (result),
        .ready     (ready),
        .sample_req(sample_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural search: number of steps from start to target
    function automatic int model_steps(input int s, input int t);
        int c;
        int e;
        int ld;
        int n;
        int d;
        int st;
        c = s; e = 0; ld = -1; n = 0;
        while (c != t && n < 200) begin
            d = (t > c) ? 1 : 0;
            if (d != ld) e = 0;
            st = 1 << e;
            if (d == 1) c = (c + st > 63) ? 63 : c + st;
            else        c = (c - st < 0) ? 0 : c - st;
            e = (e < 5) ? e + 1 : 5;
            ld = d;
            n++;
        end
        return n;
    endfunction

    int cur = 31;

    // Called at the negedge of a fetch cycle
    task automatic do_sample(input int target, input string tag);
        int exp_n;
        int n;
        exp_n = model_steps(cur, target);
        vin = target;
        n = 0;
        @(negedge clk);
        n = 1;
        // R8: fetch cycle did not move the code although the flags may have changed
        chk(dac_code == 6'(cur), {tag, " R8 fetch keeps code"}, int'(dac_code), cur);
        while (!ready && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (!ready) chk(1'b0, {tag, " R9 watchdog"}, n, exp_n + 1);
        chk(n == exp_n + 1, {tag, " R9 cycles to ready"}, n, exp_n + 1);
        chk(dac_code == 6'(target), {tag, " R10 converged code"}, int'(dac_code), target);
        @(negedge clk);
        chk(sample_req == 1'b1, {tag, " R8 sample_req after hold"}, int'(sample_req), 1);
        chk(ready == 1'b0, {tag, " R8 ready low in fetch"}, int'(ready), 0);
        chk(result == 6'(target), {tag, " R7 result loaded"}, int'(result), target);
        chk(dac_code == 6'(target), {tag, " R6 code held"}, int'(dac_code), target);
        cur = target;
    endtask

    initial begin
        #5_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        int t;
        real ph;
        seed_dummy = $urandom(1234);
        rst = 1'b1;
        vin = 31;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dac_code == 6'd31, "R1 reset code", int'(dac_code), 31);
        chk(result == 6'd0, "R1 reset result", int'(result), 0);
        chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
        chk(sample_req == 1'b0, "R1 reset sample_req", int'(sample_req), 0);
        rst = 1'b0;

        do_sample(31, "R9 unchanged");
        do_sample(31, "R9 unchanged again");
        do_sample(32, "R9 plus one");
        do_sample(31, "R9 minus one");
        do_sample(33, "R4 reversal");
        do_sample(63, "R5 overflow clamp");
        do_sample(63, "R5 top hold");
        do_sample(40, "R2 down");
        do_sample(0, "R5 underflow clamp");
        do_sample(0, "R5 bottom hold");
        do_sample(63, "R3 doubling full range");
        do_sample(0, "R3 doubling full down");
        do_sample(17, "R4 mixed");

        for (int k = 0; k < 300; k++) begin
            ph = 6.283185307 * real'(k) / 40.0;
            t = $rtoi(31.5 + 31.0 * $sin(ph)) + int'($urandom % 5) - 2;
            if (t < 0) t = 0;
            if (t > 63) t = 63;
            do_sample(t, "R10 sine");
        end
        for (int k = 0; k < 150; k++) begin
            do_sample(int'($urandom % 64), "R3 random jump");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule